// File: doc/BRIEF.md
# Return Address Stack Controller

A four-entry hardware stack that holds only program counter values. A subroutine call or an interrupt acknowledge pushes the current return address. A return or return-from-interrupt pops the most recent entry, and the block presents that entry as the address to restore. The storage and its pointer cannot be reached through any data read or write path. The only outputs are the restored address, the occupancy flags and the interrupt gating signal.

The interrupt side sees a single gate. A pending unmasked interrupt request is passed through as an acknowledge only while the stack has a free entry. When all four entries are in use, the request stays pending outside this block. It is acknowledged once a return has freed an entry. A call made while the stack is full still pushes: the oldest entry is discarded and the four newest return addresses are kept.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the stack is empty: `empty` is 1, `full` is 0, and all four entries hold zero.
- R2: Pops return the pushed addresses in last-in, first-out order. `ret_addr` shows the most recent entry combinationally in the cycle that `pop` is high.
- R3: `full` is 1 exactly when four entries are in use, and `empty` is 1 exactly when none are in use. The occupancy never exceeds four.
- R4: `irq_ack` equals `irq_req` while the stack is not full and is 0 while it is full.
- R5: After a pop from a full stack, a held-off `irq_req` is acknowledged in the next cycle.
- R6: A push while the stack is full discards the oldest entry. The stack stays full, and the following four pops return the four newest addresses, newest first.
- R7: A pop from an empty stack leaves the pointer and the occupancy unchanged and returns the entry just below the pointer. After reset that entry is zero.
- R8: When `push` and `pop` are high in the same cycle, the pop is applied first and the push second. On a non-empty stack, `ret_addr` gives the old top, the new address replaces it, and the occupancy is unchanged. On an empty stack, the occupancy becomes one.
- R9: The address width is the parameter `PC_W`, with a default of 12 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Call or interrupt acknowledge: store `push_addr` |
| push_addr | input | PC_W | Return address to store |
| pop | input | 1 | Return: remove the top entry |
| ret_addr | output | PC_W | Current top entry, i.e. the address to restore on a pop |
| full | output | 1 | Four entries in use |
| empty | output | 1 | No entries in use |
| irq_req | input | 1 | Pending unmasked interrupt request |
| irq_ack | output | 1 | Interrupt may be acknowledged |

## Verification
The bench targets four corner cases.

- **Overflow by a fifth call.** A design that refused the push would return A as the last pop. A design that overwrote the newest slot would return the wrong sequence.
- **Interrupt gate around the full boundary.** A wrong gate either acknowledges with no room left or keeps holding off after a return has freed an entry.
- **Pop on an empty stack.** A wrong design lets the pointer or the occupancy wrap, which corrupts the next push and pop.
- **Simultaneous push and pop, on an empty and on a non-empty stack.** Applying the two in the wrong order shows up as a changed occupancy or a wrong top entry.

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int PC_W  = 12,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [PC_W-1:0] push_addr,
  input  logic            pop,
  output logic [PC_W-1:0] ret_addr,
  output logic            full,
  output logic            empty,
  input  logic            irq_req,
  output logic            irq_ack
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [PC_W-1:0] slot [DEPTH];
  logic [PW-1:0]   wp;
  logic [CW-1:0]   cnt;
  logic [PW-1:0]   top_idx;
  logic            do_pop;

  assign top_idx  = wp - 1'b1;
  assign ret_addr = slot[top_idx];
  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);
  assign irq_ack  = irq_req & ~full;
  assign do_pop   = pop & ~empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (push && do_pop) begin
      slot[top_idx] <= push_addr;
    end else if (push) begin
      slot[wp] <= push_addr;
      wp       <= wp + 1'b1;
      if (!full) cnt <= cnt + 1'b1;
    end else if (do_pop) begin
      wp  <= top_idx;
      cnt <= cnt - 1'b1;
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_no_ack_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !irq_ack);
  p_overflow_stays_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
  p_empty_pop_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty && $stable(ret_addr));
  p_pop_then_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty) |=> ret_addr == $past(push_addr) && $stable(cnt));
  p_pop_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pop && !push) |=> !full);
endmodule

// File: tb/ret_addr_stack_bench.sv
module ret_addr_stack_bench;
  localparam int PC_W = 12;
  logic clk = 0, rst_n = 0, push = 0, pop = 0, irq_req = 0;
  logic [PC_W-1:0] push_addr = '0, ret_addr;
  logic full, empty, irq_ack;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ret_addr_stack #(.PC_W(PC_W)) u_ret_addr_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .push_addr(push_addr), .pop(pop),
    .ret_addr(ret_addr), .full(full), .empty(empty),
    .irq_req(irq_req), .irq_ack(irq_ack));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle of push/pop at negedge; returns ret_addr seen before the edge
  task automatic step(input logic pu, input logic po, input logic [PC_W-1:0] a,
                      output logic [PC_W-1:0] seen);
    push = pu; pop = po; push_addr = a;
    #1 seen = ret_addr;
    @(posedge clk); @(negedge clk);
    push = 0; pop = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; @(posedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    logic [PC_W-1:0] s;
    do_reset();
    check("R1 empty", empty, 1); check("R1 full", full, 0);
    irq_req = 1; #1 check("R4 ack when not full", irq_ack, 1); irq_req = 0;
    step(0, 1, 0, s);
    check("R1/R7 empty pop value", s, 0);
    check("R7 still empty", empty, 1);
    step(1, 0, 12'h5A5, s);
    check("R7 one entry after push", empty, 0);
    step(0, 1, 0, s);
    check("R7 push-pop after empty pop", s, 12'h5A5);
    check("R7 empty again", empty, 1);
  endtask

  task automatic t_lifo();
    logic [PC_W-1:0] s;
    do_reset();
    step(1, 0, 12'h111, s); step(1, 0, 12'h222, s); step(1, 0, 12'hFFF, s);
    check("R3 three not full", full, 0);
    step(0, 1, 0, s); check("R2 pop 1", s, 12'hFFF);
    step(0, 1, 0, s); check("R2 pop 2", s, 12'h222);
    step(0, 1, 0, s); check("R2 pop 3", s, 12'h111);
    check("R3 empty after drain", empty, 1);
  endtask

  task automatic t_full_irq();
    logic [PC_W-1:0] s;
    do_reset();
    for (int i = 0; i < 4; i++) step(1, 0, PC_W'(12'h100 + i), s);
    check("R3 full at four", full, 1);
    irq_req = 1; #1;
    check("R4 ack held off", irq_ack, 0);
    step(0, 1, 0, s);
    check("R5 pop value", s, 12'h103);
    check("R5 ack after return", irq_ack, 1);
    irq_req = 0;
  endtask

  task automatic t_overflow();
    logic [PC_W-1:0] s;
    do_reset();
    for (int i = 0; i < 5; i++) step(1, 0, PC_W'(12'hA00 + i), s);
    check("R6 still full", full, 1);
    for (int i = 4; i >= 1; i--) begin
      step(0, 1, 0, s);
      check("R6 newest four", s, 12'hA00 + i);
    end
    check("R6 empty after four pops", empty, 1);
  endtask

  task automatic t_both();
    logic [PC_W-1:0] s;
    do_reset();
    step(1, 1, 12'h0C3, s);
    check("R8 empty both -> one entry", empty, 0);
    step(1, 0, 12'h0D4, s);
    step(1, 1, 12'h0E5, s);
    check("R8 old top returned", s, 12'h0D4);
    step(0, 1, 0, s); check("R8 new top", s, 12'h0E5);
    step(0, 1, 0, s); check("R8 below unchanged", s, 12'h0C3);
    check("R8 occupancy unchanged then drained", empty, 1);
    for (int i = 0; i < 4; i++) step(1, 0, PC_W'(12'h700 + i), s);
    step(1, 1, 12'h7FF, s);
    check("R8 full both stays full", full, 1);
    check("R9 width", $bits(ret_addr), 12);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset(); t_lifo(); t_full_irq(); t_overflow(); t_both();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule